// File: doc/BRIEF.md
# Streaming Q8 Three/Five-Tap FIR Filter

This block filters a stream of unsigned 8-bit samples with a short FIR kernel whose coefficients are signed Q8 values, meaning real gains scaled by 256. A parameter sets the kernel length to three taps, or to five taps for one fused kernel that stands in for two chained three-tap stages. The previous samples sit in a rotating register window. Each output therefore reads only the newly accepted sample, and the filter keeps a rate of one sample per clock.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream one cycle later. The accumulator is preloaded with the half-LSB rounding constant. The sum is shifted right arithmetically by eight and clamped to the 8-bit range. After reset, results are withheld until the window is full. A coefficient port loads taps one at a time. A write is accepted only while the block is idle.

Top module: `fir_stream`

## Requirements
- R1: Each output equals floor((c0·x(n) + c1·x(n−1) + … + c(N−1)·x(n−N+1) + 128) / 256). Samples are unsigned 8-bit values and coefficients are signed CW-bit two's complement values.
- R2: A result below 0 is output as 0, and a result above 255 is output as 255.
- R3: x(n−k) is the sample accepted k transfers before the current one. Cycles without a transfer do not move the window.
- R4: After reset, the first N−1 accepted samples produce no output. Every later accepted sample produces exactly one output.
- R5: While out_ready is high, in_ready stays high. Each accepted sample appears on out_data with out_valid in the following cycle.
- R6: While out_valid is high and out_ready is low, out_valid and out_data hold and in_ready is low, so no sample is lost or repeated.
- R7: A write with coef_idx = k (k < N) sets coefficient ck, which multiplies x(n−k). A write with coef_idx ≥ N changes nothing.
- R8: A coefficient write in a cycle where in_valid or out_valid is high is ignored.
- R9: Reset clears out_valid, raises in_ready and sets all coefficients to zero.
- R10: With NTAPS = 5, the filter applies five taps. Loading the rounded Q8 convolution of two three-tap kernels gives the fused response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | $clog2(NTAPS)+1 | Tap index of the write |
| coef_data | input | CW | Signed Q8 coefficient value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Filter can accept a sample |
| in_data | input | DW | Unsigned input sample |
| out_valid | output | 1 | Filtered result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | DW | Rounded, saturated result |

## Verification
The case that is hardest to reach from the ports is a coefficient write that must be dropped because a result is parked at the output. The bench holds out_ready low until a finished sample waits in the output register. It then issues writes, some of them alongside a live input, and releases the stall. The next results are compared against a model that kept the old coefficients. Coefficient sweeps over all 256 input values cover rounding at both signs and saturation at both ends, while a pseudo-random out_ready pattern exercises the stalls.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int ACC_MAX_W = 40;
  typedef logic signed [ACC_MAX_W-1:0] acc_t;

  // Arithmetic right shift: floor division by 2**frac
  function automatic acc_t q_shift(input acc_t a, input int unsigned frac);
    return a >>> frac;
  endfunction

  // Clamp a scaled value into [0, maxv]
  function automatic acc_t clamp_u(input acc_t a, input acc_t maxv);
    if (a < 0) return '0;
    if (a > maxv) return maxv;
    return a;
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int NTAPS = 3,
  parameter int CW    = 10,
  localparam int IW   = $clog2(NTAPS) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IW-1:0]         idx,
  input  logic [CW-1:0]         wdata,
  input  logic                  busy,
  output logic [NTAPS*CW-1:0]   coef_flat
);
  logic wr_ok;
  assign wr_ok = we && !busy;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          coef_flat[k*CW +: CW] <= '0;
      else if (wr_ok && idx == IW'(k))     coef_flat[k*CW +: CW] <= wdata;
    end
  end

  // R8: a write attempted while the stream is active leaves every tap alone
  p_coef_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy) |=> $stable(coef_flat));
endmodule

// File: rtl/fir_window.sv
module fir_window #(
  parameter int NTAPS = 3,
  parameter int DW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic [DW-1:0]        din,
  output logic [NTAPS*DW-1:0]  taps
);
  localparam int HN = NTAPS - 1;
  logic [DW-1:0] hist [HN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < HN; j++) hist[j] <= '0;
    end else if (shift) begin
      hist[0] <= din;
      for (int j = 1; j < HN; j++) hist[j] <= hist[j-1];
    end
  end

  assign taps[0 +: DW] = din;
  for (genvar j = 0; j < HN; j++) begin : g_out
    assign taps[(j+1)*DW +: DW] = hist[j];
  end

  // R3: newest slot takes the accepted sample; idle cycles keep the oldest
  p_window_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> hist[0] == $past(din));
  p_window_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(hist[HN-1]));
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int NTAPS = 3,
  parameter int DW    = 8,
  parameter int CW    = 10,
  parameter int FRAC  = 8,
  parameter int ACCW  = 22
) (
  input  logic [NTAPS*DW-1:0]    taps,
  input  logic [NTAPS*CW-1:0]    coef_flat,
  output logic signed [ACCW-1:0] acc
);
  always_comb begin
    acc = ACCW'(1) <<< (FRAC - 1);
    for (int k = 0; k < NTAPS; k++) begin
      logic signed [ACCW-1:0] xs;
      logic signed [ACCW-1:0] cs;
      xs = ACCW'($signed({1'b0, taps[k*DW +: DW]}));
      cs = ACCW'($signed(coef_flat[k*CW +: CW]));
      acc = acc + xs * cs;
    end
  end
endmodule

// File: rtl/fir_stream.sv
module fir_stream #(
  parameter int DW    = 8,
  parameter int CW    = 10,
  parameter int NTAPS = 3,
  parameter int FRAC  = 8,
  localparam int IW   = $clog2(NTAPS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_we,
  input  logic [IW-1:0] coef_idx,
  input  logic [CW-1:0] coef_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import fir_pkg::*;

  localparam int ACCW = DW + CW + $clog2(NTAPS) + 2;
  localparam int WW   = $clog2(NTAPS);
  localparam int MAXV = (1 << DW) - 1;

  logic                  in_fire;
  logic                  busy;
  logic                  warm_full;
  logic [WW-1:0]         warm_cnt;
  logic [NTAPS*CW-1:0]   coef_flat;
  logic [NTAPS*DW-1:0]   taps;
  logic signed [ACCW-1:0] acc;
  acc_t                  scaled;
  acc_t                  clipped;

  assign in_ready  = !out_valid || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign busy      = in_valid || out_valid;
  assign warm_full = (warm_cnt == WW'(NTAPS - 1));

  fir_coef_bank #(.NTAPS(NTAPS), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .idx(coef_idx),
    .wdata(coef_data), .busy(busy), .coef_flat(coef_flat)
  );

  fir_window #(.NTAPS(NTAPS), .DW(DW)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(in_fire), .din(in_data), .taps(taps)
  );

  fir_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .FRAC(FRAC), .ACCW(ACCW)) u_mac (
    .taps(taps), .coef_flat(coef_flat), .acc(acc)
  );

  assign scaled  = q_shift(acc_t'(acc), FRAC);
  assign clipped = clamp_u(scaled, acc_t'(MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      warm_cnt  <= '0;
    end else if (in_fire) begin
      out_data  <= clipped[DW-1:0];
      out_valid <= warm_full;
      if (!warm_full) warm_cnt <= warm_cnt + 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: a refused result is held unchanged
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R5: a result only appears one cycle after an accepted sample
  p_rise_needs_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_fire));
  // R4: samples taken during warm-up do not raise out_valid
  p_warm_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !warm_full) |=> !out_valid);
endmodule

// File: tb/test_fir_stream.sv
module test_fir_stream;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [2:0] coef_idx = '0;
  logic [9:0] coef_data = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b1;
  logic ir0, ir1, ov0, ov1;
  logic [7:0] od0, od1;

  always #4 clk = ~clk;  // 125 MHz

  fir_stream #(.NTAPS(3)) i_fir_stream (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .in_valid(in_valid), .in_ready(ir0), .in_data(in_data),
    .out_valid(ov0), .out_ready(out_ready), .out_data(od0));

  fir_stream #(.NTAPS(5)) i_fir_stream_f (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .in_valid(in_valid), .in_ready(ir1), .in_data(in_data),
    .out_valid(ov1), .out_ready(out_ready), .out_data(od1));

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R9";
  int ntap [2] = '{3, 5};
  int hist [2][5];
  int coefm [2][5];
  int nacc [2];
  int exq [2][8192];
  int wp [2], rp [2];
  int pv [2], pd [2];
  int pops0 = 0;
  int stall_mode = 0;  // 0 ready, 1 pseudo-random, 2 held low
  int fs = 0;
  logic [7:0] lfsr = 8'hA5;

  function automatic int ref_out(int k);
    int s, q;
    s = 128;
    for (int t = 0; t < ntap[k]; t++) s += hist[k][t] * coefm[k][t];
    q = s / 256;
    if (s < 0 && (s % 256) != 0) q = q - 1;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  task automatic fail(string req, int k, int got, int exp);
    errors++;
    $display("FAIL %s inst%0d: got %0d expected %0d", req, k, got, exp);
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= (stall_mode == 0) ? 1'b1 : (stall_mode == 1) ? lfsr[0] | lfsr[3] : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        int ir, ov, od;
        ir = (k == 0) ? int'(ir0) : int'(ir1);
        ov = (k == 0) ? int'(ov0) : int'(ov1);
        od = (k == 0) ? int'(od0) : int'(od1);
        if (pv[k] != 0) begin
          checks++;
          if (ov == 0 || od != pd[k]) fail("R6", k, od, pd[k]);
        end
        if (in_valid && ir != 0) begin
          for (int t = 4; t > 0; t--) hist[k][t] = hist[k][t-1];
          hist[k][0] = int'(in_data);
          nacc[k]++;
          if (nacc[k] >= ntap[k]) begin
            exq[k][wp[k] % 8192] = ref_out(k);
            wp[k]++;
          end
        end
        if (ov != 0 && out_ready) begin
          checks++;
          if (rp[k] == wp[k]) fail("R4", k, od, -1);
          else begin
            if (od != exq[k][rp[k] % 8192]) fail(cur_req, k, od, exq[k][rp[k] % 8192]);
            rp[k]++;
          end
          if (k == 0) pops0++;
        end
        if (coef_we && !in_valid && ov == 0 && int'(coef_idx) < ntap[k])
          coefm[k][coef_idx] = int'($signed(coef_data));
        pv[k] = (ov != 0 && !out_ready) ? 1 : 0;
        pd[k] = od;
      end
      if (fs != 0 && !ir0) begin
        checks++;
        fail("R5", 0, 0, 1);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected <150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic send(input int v);
    @(posedge clk);
    in_valid <= 1'b1;
    in_data  <= v[7:0];
    do @(negedge clk); while (!ir0);
  endtask

  task automatic idle(input int n);
    @(posedge clk);
    in_valid <= 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input int idx, input int val);
    @(posedge clk);
    coef_we   <= 1'b1;
    coef_idx  <= idx[2:0];
    coef_data <= val[9:0];
    @(posedge clk);
    coef_we   <= 1'b0;
  endtask

  task automatic drain();
    stall_mode = 0;
    idle(6);
  endtask

  int sets [9][5] = '{
    '{0, 0, 0, 0, 0},
    '{256, 0, 0, 0, 0},
    '{0, 256, 0, 0, 0},
    '{0, 0, 256, 0, 256},
    '{85, 86, 85, 0, 0},
    '{511, 511, 511, 511, 511},
    '{-512, -1, -300, -200, -5},
    '{100, -50, 37, -77, 3},
    '{0, 0, 0, 0, 0}};

  initial begin
    int k1 [3] = '{64, 128, 64};
    int k2 [3] = '{32, 192, 32};
    for (int i = 0; i < 2; i++) begin
      wp[i] = 0; rp[i] = 0; nacc[i] = 0; pv[i] = 0; pd[i] = 0;
      for (int t = 0; t < 5; t++) begin hist[i][t] = 0; coefm[i][t] = 0; end
    end
    // fused kernel: rounded Q8 convolution of k1 and k2 (R10)
    for (int n = 0; n < 5; n++) begin
      int s = 0;
      for (int i = 0; i < 3; i++)
        if (n - i >= 0 && n - i < 3) s += k1[i] * k2[n-i];
      sets[8][n] = (s + 128) / 256;
    end
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    checks++; if (ov0 || ov1) fail("R9", 0, int'(ov0) + int'(ov1), 0);
    checks++; if (!ir0 || !ir1) fail("R9", 0, int'(ir0) + int'(ir1), 2);

    // R4 warm-up with reset coefficients (R9: all-zero gives 0)
    cur_req = "R4";
    send(200); send(90); idle(2);
    @(negedge clk);
    checks++; if (ov0) fail("R4", 0, 1, 0);
    checks++; if (ov1) fail("R4", 1, 1, 0);
    cur_req = "R9";
    for (int v = 0; v < 6; v++) send(200 + v);
    drain();

    // Coefficient sweeps over every input value, with random backpressure
    for (int s = 1; s < 9; s++) begin
      for (int t = 0; t < 5; t++) wr(t, sets[s][t]);  // idx 3,4 ignored by 3-tap: R7
      case (s)
        1, 2, 3: cur_req = "R3";
        4, 7:    cur_req = "R1";
        5, 6:    cur_req = "R2";
        default: cur_req = "R10";
      endcase
      stall_mode = (s % 2 == 1) ? 1 : 0;
      for (int v = 0; v < 256; v++) begin
        send((v * 37 + s * 11) % 256);
        if (v % 50 == 49) begin idle(1); end
      end
      drain();
    end

    // R7: write to an index beyond the 3-tap range
    cur_req = "R7";
    wr(0, 256); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 99);
    wr(7, 311);
    for (int v = 0; v < 20; v++) send(v * 12);
    drain();

    // R8: writes while a result is parked, and alongside a live input
    cur_req = "R8";
    stall_mode = 2;
    send(77); idle(2);
    wr(0, -400); wr(1, 300);
    stall_mode = 0;
    @(posedge clk);
    coef_we <= 1'b1; coef_idx <= 3'd2; coef_data <= 10'd500;
    in_valid <= 1'b1; in_data <= 8'd150;
    do @(negedge clk); while (!ir0);
    @(posedge clk);
    coef_we <= 1'b0; in_valid <= 1'b0;
    for (int v = 0; v < 16; v++) send(255 - v * 9);
    drain();

    // R5: full rate
    cur_req = "R5";
    begin
      int base;
      base = pops0;
      send(1);
      fs = 1;
      for (int v = 0; v < 63; v++) send(v * 4);
      @(posedge clk);
      fs = 0;
      in_valid <= 1'b0;
      repeat (4) @(posedge clk);
      checks++;
      if (pops0 - base != 64) fail("R5", 0, pops0 - base, 64);
    end
    drain();
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (rp[i] != wp[i]) fail("R4", i, rp[i], wp[i]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule